// File: doc/BRIEF.md
# Pixel-Stage Interrupt Register Block

This block is the host-facing status and control unit at the end of a graphics pixel pipeline. The pipeline tells it when a drawing token has been reached and when a frame is finished. The block records each of these as a sticky pending bit, gates that bit with a host-programmed enable, and drives it onto a fixed bit of a 16-bit interrupt-cause vector. The host clears a pending event by writing a one to a write-only acknowledge bit in the same control word that holds the enables.

Beside the two events, the block exposes several read-only values over a 16-bit register port. These are the most recent token value, a set of 32-bit event counters readable as two 16-bit halves, and four bounding-box words. Reading any bounding-box word drops a bounding-box-active flag. Two waiting flags show whether a token or finish has been announced by the pipeline but not yet applied.

Top module: `pxe_irq_regs`

## Requirements
- R1: An active-low asynchronous reset sets the enables, both pending bits, the token register, both waiting flags, all counters, the bounding-box-active flag, `host_rdata` and `irq_cause` to zero.
- R2: A write to byte address 0x00 stores bit 0 as the token enable and bit 1 as the finish enable. A read of 0x00 returns the two enables in bits 1:0 and zero in bits 15:2, so the acknowledge bits (bit 2 token, bit 3 finish) always read as 0.
- R3: `irq_cause[9]` is the token pending bit AND the token enable, and `irq_cause[10]` is the finish pending bit AND the finish enable. All other cause bits are 0. A cleared enable masks the interrupt without clearing the pending bit. The cause follows any state change on the cycle after the edge.
- R4: A control write with bit 2 set clears the token pending bit, and a control write with bit 3 set clears the finish pending bit. A zero in these bits leaves the pending bit unchanged.
- R5: When an acknowledge and a new occurrence of the same event fall in the same cycle, the pending bit stays set.
- R6: A `tok_set` pulse always loads `tok_value` into the token register, which reads back at address 0x02. It sets the token pending bit only when `tok_irq_req` is 1.
- R7: A `fin_set` pulse sets the finish pending bit.
- R8: `tok_issue` and `fin_issue` set their waiting flags. `tok_set` and `fin_set` clear them. If the issue and the clear arrive in the same cycle, the flag ends set.
- R9: Each `cnt_inc[i]` pulse adds one to 32-bit counter i. The counter's low half reads at 0x20+4*i and its high half at 0x22+4*i.
- R10: Writes to the token, counter and bounding-box addresses change nothing.
- R11: Bounding-box word j (bits 16*j+15:16*j of `bbox_val`) reads at 0x10+2*j. `bbox_set` raises `bbox_active`. A read of any bounding-box address clears it on the next cycle, unless `bbox_set` arrives in the same cycle, in which case the flag stays set.
- R12: `host_rdata` carries the addressed value on the cycle after `host_rd` and holds its value while no read is made. Odd or unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| tok_set | input | 1 | Token event pulse |
| tok_value | input | 16 | Token value carried with the pulse |
| tok_irq_req | input | 1 | Token event requests an interrupt |
| tok_issue | input | 1 | Token announced, not yet applied |
| fin_set | input | 1 | Frame finished pulse |
| fin_issue | input | 1 | Finish announced, not yet applied |
| irq_cause | output | 16 | Interrupt cause vector (bit 9 token, bit 10 finish) |
| tok_wait | output | 1 | Token waiting flag |
| fin_wait | output | 1 | Finish waiting flag |
| cnt_inc | input | NUM_CNT | Per-counter increment pulses |
| bbox_val | input | 16*NUM_BBOX | Bounding-box words |
| bbox_set | input | 1 | Sets the bounding-box-active flag |
| bbox_active | output | 1 | Bounding-box-active flag |

## Verification
The first patterns are isolated events with the enables on and off. These separate the masking done by the enable from the clearing done by an acknowledge, and a token without an interrupt request shows that the value path and the pending path are independent. The next patterns put an acknowledge and an event in the same cycle, and an issue and an apply in the same cycle. These pin down which side wins each collision. A long run on one counter carries into its high half, and writes to read-only addresses followed by reads show that those writes are dropped. A seeded random mix of all inputs, checked every cycle against a bench model, covers the interleavings the directed cases do not reach.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
  // Register half-word width seen by the host
  localparam int unsigned HW = 16;

  // Byte offsets of the register window
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_TOKEN  = 'h02;
  localparam int unsigned OFS_BBOX   = 'h10;
  localparam int unsigned OFS_CNT    = 'h20;
  localparam int unsigned CNT_STRIDE = 4;

  // Control word bit positions (enable of event e at e, acknowledge at e+2)
  localparam int unsigned BIT_TOK_EN  = 0;
  localparam int unsigned BIT_FIN_EN  = 1;
  localparam int unsigned BIT_TOK_ACK = 2;
  localparam int unsigned BIT_FIN_ACK = 3;

  // Cause vector positions
  localparam int unsigned CAUSE_TOK = 9;
  localparam int unsigned CAUSE_FIN = 10;

  // Event slot indices
  localparam int unsigned EVT_TOK = 0;
  localparam int unsigned EVT_FIN = 1;
  localparam int unsigned NUM_EVT = 2;

  typedef struct packed {
    logic en;
    logic pend;
    logic wt;
  } slot_state_t;
endpackage

// File: rtl/pxe_evt_slot.sv
module pxe_evt_slot
  import pxe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_en,
  input  logic cfg_ack,
  input  logic raise,
  input  logic done,
  input  logic issue,
  output logic en,
  output logic pend,
  output logic wt,
  output logic irq
);
  slot_state_t st_q;
  slot_state_t st_d;
  logic        st_ce;

  // Next state: acknowledge first, then a new occurrence overrides it
  always_comb begin
    st_d = st_q;
    if (cfg_wr) begin
      st_d.en = cfg_en;
      if (cfg_ack) st_d.pend = 1'b0;
    end
    if (raise) st_d.pend = 1'b1;
    if (done)  st_d.wt   = 1'b0;
    if (issue) st_d.wt   = 1'b1;
  end

  assign st_ce = cfg_wr | raise | done | issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_ce) st_q <= st_d;
  end

  assign en   = st_q.en;
  assign pend = st_q.pend;
  assign wt   = st_q.wt;
  assign irq  = st_q.pend & st_q.en;
endmodule

// File: rtl/pxe_cnt_bank.sv
module pxe_cnt_bank #(
  parameter int unsigned NUM_CNT = 3,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       inc,
  output logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb cnt_d = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (inc[i]) cnt_q <= cnt_d;
    end

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/pxe_rd_mux.sv
module pxe_rd_mux
  import pxe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CNT  = 3,
  parameter int unsigned NUM_BBOX = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd,
  input  logic [HW-1:0]             ctrl_word,
  input  logic [HW-1:0]             tok_word,
  input  logic [NUM_BBOX*HW-1:0]    bbox_flat,
  input  logic [NUM_CNT*2*HW-1:0]   cnt_flat,
  output logic                      bbox_hit,
  output logic [HW-1:0]             rdata
);
  localparam int unsigned CNT_W = 2 * HW;

  logic [HW-1:0] rd_d;

  // Address decode; anything not matched returns zero
  always_comb begin
    rd_d     = '0;
    bbox_hit = 1'b0;
    if (addr == ADDR_W'(OFS_CTRL))  rd_d = ctrl_word;
    if (addr == ADDR_W'(OFS_TOKEN)) rd_d = tok_word;
    for (int j = 0; j < NUM_BBOX; j++) begin
      if (addr == ADDR_W'(OFS_BBOX + 2 * j)) begin
        rd_d     = bbox_flat[j*HW +: HW];
        bbox_hit = 1'b1;
      end
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == ADDR_W'(OFS_CNT + CNT_STRIDE * i))
        rd_d = cnt_flat[i*CNT_W +: HW];
      if (addr == ADDR_W'(OFS_CNT + CNT_STRIDE * i + 2))
        rd_d = cnt_flat[i*CNT_W + HW +: HW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_d;
  end
endmodule

// File: rtl/pxe_irq_regs.sv
module pxe_irq_regs
  import pxe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CNT  = 3,
  parameter int unsigned NUM_BBOX = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic                   host_rd,
  input  logic                   host_wr,
  input  logic [HW-1:0]          host_wdata,
  output logic [HW-1:0]          host_rdata,
  input  logic                   tok_set,
  input  logic [HW-1:0]          tok_value,
  input  logic                   tok_irq_req,
  input  logic                   tok_issue,
  input  logic                   fin_set,
  input  logic                   fin_issue,
  output logic [HW-1:0]          irq_cause,
  output logic                   tok_wait,
  output logic                   fin_wait,
  input  logic [NUM_CNT-1:0]     cnt_inc,
  input  logic [NUM_BBOX*HW-1:0] bbox_val,
  input  logic                   bbox_set,
  output logic                   bbox_active
);
  localparam int unsigned CNT_W = 2 * HW;

  logic                 ctrl_wr;
  logic [NUM_EVT-1:0]   s_raise;
  logic [NUM_EVT-1:0]   s_done;
  logic [NUM_EVT-1:0]   s_issue;
  logic [NUM_EVT-1:0]   slot_en;
  logic [NUM_EVT-1:0]   slot_pend;
  logic [NUM_EVT-1:0]   slot_wt;
  logic [NUM_EVT-1:0]   slot_irq;
  logic [HW-1:0]        ctrl_word;
  logic [HW-1:0]        tok_q;
  logic [HW-1:0]        tok_d;
  logic                 bbox_q;
  logic                 bbox_d;
  logic                 bbox_hit;
  logic                 bbox_clr;
  logic [NUM_CNT*CNT_W-1:0] cnt_flat;
  logic                 wdata_unused;

  assign ctrl_wr      = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
  assign wdata_unused = ^host_wdata[HW-1:BIT_FIN_ACK+1];

  // Event slot inputs, indexed by EVT_TOK / EVT_FIN
  assign s_raise[EVT_TOK] = tok_set & tok_irq_req;
  assign s_raise[EVT_FIN] = fin_set;
  assign s_done[EVT_TOK]  = tok_set;
  assign s_done[EVT_FIN]  = fin_set;
  assign s_issue[EVT_TOK] = tok_issue;
  assign s_issue[EVT_FIN] = fin_issue;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_slot
    pxe_evt_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (ctrl_wr),
      .cfg_en  (host_wdata[BIT_TOK_EN + e]),
      .cfg_ack (host_wdata[BIT_TOK_ACK + e]),
      .raise   (s_raise[e]),
      .done    (s_done[e]),
      .issue   (s_issue[e]),
      .en      (slot_en[e]),
      .pend    (slot_pend[e]),
      .wt      (slot_wt[e]),
      .irq     (slot_irq[e])
    );
  end

  always_comb begin
    irq_cause            = '0;
    irq_cause[CAUSE_TOK] = slot_irq[EVT_TOK];
    irq_cause[CAUSE_FIN] = slot_irq[EVT_FIN];
  end

  always_comb begin
    ctrl_word             = '0;
    ctrl_word[BIT_TOK_EN] = slot_en[EVT_TOK];
    ctrl_word[BIT_FIN_EN] = slot_en[EVT_FIN];
  end

  assign tok_wait = slot_wt[EVT_TOK];
  assign fin_wait = slot_wt[EVT_FIN];

  // Token value register: loaded on every token event
  always_comb tok_d = tok_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tok_q <= '0;
    else if (tok_set) tok_q <= tok_d;
  end

  // Bounding-box-active flag: a new set wins over a clearing read
  assign bbox_clr = host_rd & bbox_hit;

  always_comb begin
    bbox_d = bbox_q;
    if (bbox_clr) bbox_d = 1'b0;
    if (bbox_set) bbox_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    bbox_q <= 1'b0;
    else if (bbox_clr | bbox_set) bbox_q <= bbox_d;
  end

  assign bbox_active = bbox_q;

  pxe_cnt_bank #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cnt_inc),
    .cnt_flat (cnt_flat)
  );

  pxe_rd_mux #(
    .ADDR_W   (ADDR_W),
    .NUM_CNT  (NUM_CNT),
    .NUM_BBOX (NUM_BBOX)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (host_addr),
    .rd        (host_rd),
    .ctrl_word (ctrl_word),
    .tok_word  (tok_q),
    .bbox_flat (bbox_val),
    .cnt_flat  (cnt_flat),
    .bbox_hit  (bbox_hit),
    .rdata     (host_rdata)
  );
endmodule

// File: rtl/pxe_irq_regs_chk.sv
module pxe_irq_regs_chk
  import pxe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_BBOX = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic [HW-1:0]     host_wdata,
  input logic [HW-1:0]     host_rdata,
  input logic              tok_set,
  input logic [HW-1:0]     tok_value,
  input logic              tok_irq_req,
  input logic              fin_set,
  input logic              fin_issue,
  input logic [HW-1:0]     irq_cause,
  input logic              fin_wait,
  input logic              bbox_set,
  input logic              bbox_active,
  input logic              tok_pend,
  input logic              fin_pend,
  input logic [HW-1:0]     tok_word
);
  logic ctrl_w;
  logic bbox_rd;

  assign ctrl_w  = host_wr && (host_addr == ADDR_W'(OFS_CTRL));
  assign bbox_rd = host_rd && !host_addr[0] &&
                   (host_addr >= ADDR_W'(OFS_BBOX)) &&
                   (host_addr <  ADDR_W'(OFS_BBOX + 2 * NUM_BBOX));

  p_enable_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && !host_wdata[BIT_TOK_EN] |=> !irq_cause[CAUSE_TOK]);

  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && (host_addr == ADDR_W'(OFS_CTRL)) |=> host_rdata[HW-1:2] == '0);

  p_tok_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && host_wdata[BIT_TOK_ACK] && !(tok_set && tok_irq_req) |=> !tok_pend);

  p_fin_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && host_wdata[BIT_FIN_ACK] && !fin_set |=> !fin_pend);

  p_tok_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && host_wdata[BIT_TOK_ACK] && tok_set && tok_irq_req |=> tok_pend);

  p_fin_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && host_wdata[BIT_FIN_ACK] && fin_set |=> fin_pend);

  p_tok_value_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_set |=> tok_word == $past(tok_value));

  p_tok_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_set && !tok_irq_req && !ctrl_w |=> $stable(tok_pend));

  p_fin_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_set |=> fin_pend);

  p_fin_wait_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_set && !fin_issue |=> !fin_wait);

  p_fin_wait_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_issue |=> fin_wait);

  p_bbox_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bbox_rd && !bbox_set |=> !bbox_active);

  p_bbox_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bbox_set |=> bbox_active);

  p_odd_addr_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr[0] |=> host_rdata == '0);
endmodule

bind pxe_irq_regs pxe_irq_regs_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_BBOX (NUM_BBOX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_rd     (host_rd),
  .host_wr     (host_wr),
  .host_wdata  (host_wdata),
  .host_rdata  (host_rdata),
  .tok_set     (tok_set),
  .tok_value   (tok_value),
  .tok_irq_req (tok_irq_req),
  .fin_set     (fin_set),
  .fin_issue   (fin_issue),
  .irq_cause   (irq_cause),
  .fin_wait    (fin_wait),
  .bbox_set    (bbox_set),
  .bbox_active (bbox_active),
  .tok_pend    (slot_pend[0]),
  .fin_pend    (slot_pend[1]),
  .tok_word    (tok_q)
);

// File: tb/tb_pxe_irq_regs.sv
module tb_pxe_irq_regs;
  logic        clk;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic        host_rd;
  logic        host_wr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        tok_set;
  logic [15:0] tok_value;
  logic        tok_irq_req;
  logic        tok_issue;
  logic        fin_set;
  logic        fin_issue;
  logic [15:0] irq_cause;
  logic        tok_wait;
  logic        fin_wait;
  logic [2:0]  cnt_inc;
  logic [63:0] bbox_val;
  logic        bbox_set;
  logic        bbox_active;

  int n_chk;
  int n_fail;
  bit done_flag;

  // Bench model state
  logic        m_tok_en, m_fin_en, m_tok_pend, m_fin_pend;
  logic        m_tok_wait, m_fin_wait, m_bbox;
  logic [15:0] m_tok, m_rdata;
  logic [31:0] m_cnt [3];

  pxe_irq_regs dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tok_set(tok_set), .tok_value(tok_value), .tok_irq_req(tok_irq_req),
    .tok_issue(tok_issue), .fin_set(fin_set), .fin_issue(fin_issue),
    .irq_cause(irq_cause), .tok_wait(tok_wait), .fin_wait(fin_wait),
    .cnt_inc(cnt_inc), .bbox_val(bbox_val), .bbox_set(bbox_set),
    .bbox_active(bbox_active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_bbox(input logic [7:0] a);
    return (a[0] == 1'b0) && (a >= 8'h10) && (a < 8'h18);
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {14'b0, m_fin_en, m_tok_en};
    if (a == 8'h02) return m_tok;
    for (int j = 0; j < 4; j++)
      if (a == 8'(8'h10 + 2 * j)) return bbox_val[j*16 +: 16];
    for (int i = 0; i < 3; i++) begin
      if (a == 8'(8'h20 + 4 * i)) return m_cnt[i][15:0];
      if (a == 8'(8'h22 + 4 * i)) return m_cnt[i][31:16];
    end
    return 16'h0000;
  endfunction

  function automatic logic [15:0] exp_cause();
    logic [15:0] c;
    c = '0;
    c[9]  = m_tok_pend & m_tok_en;
    c[10] = m_fin_pend & m_fin_en;
    return c;
  endfunction

  task automatic model_reset();
    m_tok_en = 0; m_fin_en = 0; m_tok_pend = 0; m_fin_pend = 0;
    m_tok_wait = 0; m_fin_wait = 0; m_bbox = 0; m_tok = '0; m_rdata = '0;
    for (int i = 0; i < 3; i++) m_cnt[i] = '0;
  endtask

  task automatic model_clock();
    logic [15:0] rv;
    logic wc;
    rv = exp_read(host_addr);
    wc = host_wr && (host_addr == 8'h00);
    if (host_rd) m_rdata = rv;
    if (wc && host_wdata[2]) m_tok_pend = 1'b0;
    if (tok_set && tok_irq_req) m_tok_pend = 1'b1;
    if (wc && host_wdata[3]) m_fin_pend = 1'b0;
    if (fin_set) m_fin_pend = 1'b1;
    if (wc) begin m_tok_en = host_wdata[0]; m_fin_en = host_wdata[1]; end
    if (tok_set) m_tok = tok_value;
    if (tok_set) m_tok_wait = 1'b0;
    if (tok_issue) m_tok_wait = 1'b1;
    if (fin_set) m_fin_wait = 1'b0;
    if (fin_issue) m_fin_wait = 1'b1;
    if (host_rd && is_bbox(host_addr)) m_bbox = 1'b0;
    if (bbox_set) m_bbox = 1'b1;
    for (int i = 0; i < 3; i++) if (cnt_inc[i]) m_cnt[i] = m_cnt[i] + 32'd1;
  endtask

  task automatic compare_all();
    check("R3 cause", {16'h0, irq_cause}, {16'h0, exp_cause()});
    check("R8 tok_wait", {31'h0, tok_wait}, {31'h0, m_tok_wait});
    check("R8 fin_wait", {31'h0, fin_wait}, {31'h0, m_fin_wait});
    check("R11 bbox_active", {31'h0, bbox_active}, {31'h0, m_bbox});
    check("R12 rdata", {16'h0, host_rdata}, {16'h0, m_rdata});
  endtask

  task automatic drive_idle();
    host_addr = '0; host_rd = 0; host_wr = 0; host_wdata = '0;
    tok_set = 0; tok_value = '0; tok_irq_req = 0; tok_issue = 0;
    fin_set = 0; fin_issue = 0; cnt_inc = '0; bbox_set = 0;
  endtask

  // Inputs are set at a falling edge; the design takes them at the next
  // rising edge and the outputs are sampled at the falling edge after it.
  task automatic tick();
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_all();
    drive_idle();
  endtask

  task automatic host_op(input bit w, input bit r, input logic [7:0] a, input logic [15:0] d);
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5A5A));
    n_chk = 0; n_fail = 0; done_flag = 0;
    rst_n = 1'b0;
    bbox_val = '0;
    drive_idle();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    check("R1 cause", {16'h0, irq_cause}, 32'h0);
    check("R1 waits", {30'h0, tok_wait, fin_wait}, 32'h0);
    check("R1 bbox_active", {31'h0, bbox_active}, 32'h0);
    check("R1 rdata", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h00, 16'h0); check("R1 ctrl", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h02, 16'h0); check("R1 token", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h22, 16'h0); check("R1 counter", {16'h0, host_rdata}, 32'h0);

    // R2: enables stored, acknowledge bits read as zero
    host_op(1, 0, 8'h00, 16'hFFFF);
    host_op(0, 1, 8'h00, 16'h0); check("R2 ctrl readback", {16'h0, host_rdata}, 32'h3);

    // R6: token without request updates value only
    tok_set = 1; tok_value = 16'hBEEF; tok_irq_req = 0; tick();
    check("R6 no irq without request", {16'h0, irq_cause}, 32'h0);
    host_op(0, 1, 8'h02, 16'h0); check("R6 token value", {16'h0, host_rdata}, 32'hBEEF);
    tok_set = 1; tok_value = 16'h1234; tok_irq_req = 1; tick();
    check("R6 irq with request", {16'h0, irq_cause}, 32'h0200);

    // R3: enable masks, pending survives
    host_op(1, 0, 8'h00, 16'h0000); check("R3 masked", {16'h0, irq_cause}, 32'h0);
    host_op(1, 0, 8'h00, 16'h0001); check("R3 unmasked", {16'h0, irq_cause}, 32'h0200);

    // R4 and R7: acknowledge clears, zero acknowledge does not
    host_op(1, 0, 8'h00, 16'h0005); check("R4 token ack", {16'h0, irq_cause}, 32'h0);
    host_op(1, 0, 8'h00, 16'h0003);
    fin_set = 1; tick(); check("R7 finish raise", {16'h0, irq_cause}, 32'h0400);
    host_op(1, 0, 8'h00, 16'h0003); check("R4 no ack keeps", {16'h0, irq_cause}, 32'h0400);
    host_op(1, 0, 8'h00, 16'h000B); check("R4 finish ack", {16'h0, irq_cause}, 32'h0);

    // R5: same-cycle acknowledge and event
    fin_set = 1; host_op(1, 0, 8'h00, 16'h000B);
    check("R5 finish event wins", {16'h0, irq_cause}, 32'h0400);
    tok_set = 1; tok_irq_req = 1; tok_value = 16'h55AA; host_op(1, 0, 8'h00, 16'h000F);
    check("R5 token event wins", {16'h0, irq_cause}, 32'h0200);

    // R8: waiting flags
    tok_issue = 1; tick(); check("R8 tok issue", {31'h0, tok_wait}, 32'h1);
    tok_set = 1; tok_value = 16'h0F0F; tick(); check("R8 tok applied", {31'h0, tok_wait}, 32'h0);
    tok_issue = 1; tok_set = 1; tok_value = 16'h0F0F; tick();
    check("R8 issue wins", {31'h0, tok_wait}, 32'h1);
    fin_issue = 1; tick(); check("R8 fin issue", {31'h0, fin_wait}, 32'h1);
    fin_set = 1; tick(); check("R8 fin applied", {31'h0, fin_wait}, 32'h0);

    // R10: writes to read-only addresses are dropped
    host_op(1, 0, 8'h02, 16'hFFFF);
    host_op(0, 1, 8'h02, 16'h0); check("R10 token write ignored", {16'h0, host_rdata}, 32'h0F0F);
    host_op(1, 0, 8'h20, 16'hFFFF);
    host_op(0, 1, 8'h20, 16'h0); check("R10 counter write ignored", {16'h0, host_rdata}, 32'h0);
    bbox_val = 64'h4444_3333_2222_1111;
    host_op(1, 0, 8'h10, 16'hFFFF);
    host_op(0, 1, 8'h10, 16'h0); check("R10 bbox write ignored", {16'h0, host_rdata}, 32'h1111);

    // R11: bounding-box flag
    bbox_set = 1; tick(); check("R11 set", {31'h0, bbox_active}, 32'h1);
    host_op(0, 1, 8'h14, 16'h0);
    check("R11 word 2", {16'h0, host_rdata}, 32'h3333);
    check("R11 read clears", {31'h0, bbox_active}, 32'h0);
    bbox_set = 1; host_op(0, 1, 8'h16, 16'h0);
    check("R11 set wins", {31'h0, bbox_active}, 32'h1);
    check("R11 word 3", {16'h0, host_rdata}, 32'h4444);

    // R12: unmapped and odd reads, hold without read
    host_op(0, 1, 8'h40, 16'h0); check("R12 unmapped", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h03, 16'h0); check("R12 odd", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h02, 16'h0);
    tick(); check("R12 hold", {16'h0, host_rdata}, 32'h0F0F);

    // R9: carry into the high half
    for (int k = 0; k < 65540; k++) begin
      cnt_inc = 3'b101;
      tick();
    end
    host_op(0, 1, 8'h20, 16'h0); check("R9 cnt0 low", {16'h0, host_rdata}, 32'h4);
    host_op(0, 1, 8'h22, 16'h0); check("R9 cnt0 high", {16'h0, host_rdata}, 32'h1);
    host_op(0, 1, 8'h24, 16'h0); check("R9 cnt1 low", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h28, 16'h0); check("R9 cnt2 low", {16'h0, host_rdata}, 32'h4);
    host_op(0, 1, 8'h2A, 16'h0); check("R9 cnt2 high", {16'h0, host_rdata}, 32'h1);

    // Random mix checked against the model every cycle (R2-R12)
    for (int n = 0; n < 3000; n++) begin
      int unsigned sel;
      sel = $urandom % 16;
      case (sel)
        0, 13, 14, 15: host_addr = 8'h00;
        1:             host_addr = 8'h02;
        2, 3, 4, 5:    host_addr = 8'(8'h10 + 2 * (sel - 2));
        6, 7, 8, 9, 10, 11: host_addr = 8'(8'h20 + 2 * (sel - 6));
        default:       host_addr = 8'($urandom);
      endcase
      host_wr     = ($urandom % 4) == 0;
      host_rd     = ($urandom % 2) == 0;
      host_wdata  = 16'($urandom);
      tok_set     = ($urandom % 4) == 0;
      tok_value   = 16'($urandom);
      tok_irq_req = 1'($urandom);
      tok_issue   = ($urandom % 6) == 0;
      fin_set     = ($urandom % 5) == 0;
      fin_issue   = ($urandom % 6) == 0;
      cnt_inc     = 3'($urandom);
      bbox_set    = ($urandom % 8) == 0;
      bbox_val    = {$urandom, $urandom};
      tick();
    end

    // R1: reset from a busy state
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 cause after reset", {16'h0, irq_cause}, 32'h0);
    check("R1 waits after reset", {30'h0, tok_wait, fin_wait}, 32'h0);
    check("R1 bbox after reset", {31'h0, bbox_active}, 32'h0);
    host_op(0, 1, 8'h20, 16'h0); check("R1 counter after reset", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h02, 16'h0); check("R1 token after reset", {16'h0, host_rdata}, 32'h0);
    host_op(0, 1, 8'h00, 16'h0); check("R1 ctrl after reset", {16'h0, host_rdata}, 32'h0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule